// File: doc/BRIEF.md
# Flash Page Program Sequencer

This block stands between the external-data write port of an 8-bit CPU and an on-chip flash array. While a page-select bit in the flash control register is set, CPU data writes no longer go to data memory. Each byte is captured into a 128-byte column latch buffer at the index given by the low seven address bits. A per-byte valid mask records which bytes were loaded. The upper address bits of the most recent accepted load name the page to program.

A page program starts only after a two-byte unlock key is written to the control register. One key pair targets the main user space and a different pair targets the extra-row space. On launch the block raises a busy flag and pulses a start strobe towards the flash array. It then waits for the array's done pulse. The done pulse clears the busy flag and the valid mask. Software polls the busy flag and the page-select bit through the control register read port.

Top module: `flash_page_seq`

## Requirements
- R1: After reset, busy and page-select are 0, the start strobe is 0, the valid mask is all zero, the latch data is all zero and `ctl_rdata` reads 00h.
- R2: An accepted control write whose upper nibble is 0 copies data bit 3 into page-select. Key bytes (upper nibble nonzero) leave page-select unchanged. `ctl_rdata` is 0 except bit 3 = page-select and bit 0 = busy.
- R3: While page-select is 0, a CPU write appears in the same cycle on `mem_we`/`mem_addr`/`mem_wdata`. While page-select is 1, `mem_we` stays 0.
- R4: While page-select is 1 and not busy, a CPU write to an accepted address stores the byte at `fl_data[8*i +: 8]` with i = address bits 6..0 and sets `fl_mask[i]`. Both are visible one cycle later.
- R5: Loads are accepted only for addresses 0000h–7FFFh (user space) or FF80h–FFFFh (extra row). Any other address changes neither the data nor the mask.
- R6: `fl_page` holds address bits 15..7 of the last accepted load.
- R7: Writing 50h and then A0h as consecutive control writes makes `fl_start` 1 for exactly one cycle, starting the cycle after the A0h write. In that same cycle busy becomes 1 and `fl_space` becomes 0.
- R8: Writing 52h and then A2h does the same as R7, except that `fl_space` becomes 1 (extra row).
- R9: After a first key byte, any other control write returns the detector to idle without launching. This includes the other space's second byte, a repeated first byte and a configuration write. A lone second byte in idle does nothing.
- R10: While busy, control writes and CPU loads are ignored. Page-select, mask, data, page and key state keep their values.
- R11: `fl_done` while busy clears busy and the whole valid mask in the next cycle. `fl_done` while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | CPU external-data write strobe |
| cpu_addr | input | 16 | CPU data pointer address |
| cpu_wdata | input | 8 | CPU accumulator write data |
| ctl_we | input | 1 | Flash control register write strobe |
| ctl_wdata | input | 8 | Flash control register write data |
| ctl_rdata | output | 8 | Control register read value (bit 3 page-select, bit 0 busy) |
| mem_we | output | 1 | Forwarded write strobe to data memory |
| mem_addr | output | 16 | Forwarded data memory address |
| mem_wdata | output | 8 | Forwarded data memory write data |
| fl_start | output | 1 | One-cycle program start to the flash array |
| fl_space | output | 1 | Target space: 0 user, 1 extra row |
| fl_page | output | 9 | Page number (address bits 15..7 of last load) |
| fl_data | output | 1024 | Column latch contents, byte i at bits 8*i+7..8*i |
| fl_mask | output | 128 | Per-byte valid mask |
| fl_done | input | 1 | Flash array done pulse |

## Verification
The hardest state to reach is a load attempt while a program is running with page-select still set. That is the only way to show that busy, rather than page-select, blocks a write to the buffer. Key bytes leave page-select untouched, so the stimulus first sets page-select and loads some bytes. It then launches with the key pair and keeps issuing CPU writes and control writes before it raises the done pulse. Broken and interleaved key sequences are also driven back to back, both directed and from a seeded random stream, so that every detector transition is taken.

// File: rtl/flash_page_seq.sv
module flash_page_seq #(
  parameter int ADDR_W     = 16,
  parameter int PAGE_BYTES = 128,
  parameter int DATA_W     = 8,
  parameter logic [ADDR_W-1:0] USER_TOP  = 16'h7FFF,
  parameter logic [ADDR_W-1:0] XROW_BASE = 16'hFF80,
  parameter logic [7:0] KEY_U1 = 8'h50,
  parameter logic [7:0] KEY_U2 = 8'hA0,
  parameter logic [7:0] KEY_X1 = 8'h52,
  parameter logic [7:0] KEY_X2 = 8'hA2,
  localparam int IDX_W  = $clog2(PAGE_BYTES),
  localparam int PAGE_W = ADDR_W - IDX_W,
  localparam int BUF_W  = PAGE_BYTES * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              ctl_we,
  input  logic [7:0]        ctl_wdata,
  output logic [7:0]        ctl_rdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              fl_start,
  output logic              fl_space,
  output logic [PAGE_W-1:0] fl_page,
  output logic [BUF_W-1:0]  fl_data,
  output logic [PAGE_BYTES-1:0] fl_mask,
  input  logic              fl_done
);

  typedef enum logic [1:0] {K_IDLE, K_ARM_U, K_ARM_X} key_t;

  key_t key_q;
  logic page_sel, busy;
  logic in_range, load, ctl_ok, launch_u, launch_x, finish;
  logic [IDX_W-1:0] idx;

  assign in_range = (cpu_addr <= USER_TOP) || (cpu_addr >= XROW_BASE);
  assign load     = cpu_we && page_sel && !busy && in_range;
  assign ctl_ok   = ctl_we && !busy;
  assign launch_u = ctl_ok && key_q == K_ARM_U && ctl_wdata == KEY_U2;
  assign launch_x = ctl_ok && key_q == K_ARM_X && ctl_wdata == KEY_X2;
  assign finish   = busy && fl_done;
  assign idx      = cpu_addr[IDX_W-1:0];

  assign mem_we    = cpu_we && !page_sel;
  assign mem_addr  = cpu_addr;
  assign mem_wdata = cpu_wdata;
  assign ctl_rdata = {4'b0000, page_sel, 2'b00, busy};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q    <= K_IDLE;
      page_sel <= 1'b0;
      busy     <= 1'b0;
      fl_start <= 1'b0;
      fl_space <= 1'b0;
      fl_page  <= '0;
    end else begin
      fl_start <= launch_u || launch_x;
      if (ctl_ok) begin
        if (ctl_wdata[7:4] == 4'h0) page_sel <= ctl_wdata[3];
        unique case (key_q)
          K_IDLE:  key_q <= (ctl_wdata == KEY_U1) ? K_ARM_U :
                            (ctl_wdata == KEY_X1) ? K_ARM_X : K_IDLE;
          default: key_q <= K_IDLE;
        endcase
      end
      if (launch_u || launch_x) begin
        busy     <= 1'b1;
        fl_space <= launch_x;
      end else if (finish) begin
        busy <= 1'b0;
      end
      if (load) fl_page <= cpu_addr[ADDR_W-1:IDX_W];
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_col
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        fl_data[g*DATA_W +: DATA_W] <= '0;
        fl_mask[g] <= 1'b0;
      end else if (finish) begin
        fl_mask[g] <= 1'b0;
      end else if (load && idx == IDX_W'(g)) begin
        fl_data[g*DATA_W +: DATA_W] <= cpu_wdata;
        fl_mask[g] <= 1'b1;
      end
    end
  end

  p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fl_start |-> busy);
  p_start_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fl_start |=> !fl_start);
  p_xrow_launch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (key_q == K_ARM_X && ctl_we && !busy && ctl_wdata == KEY_X2) |=> (fl_start && fl_space));
  p_bad_key_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (key_q != K_IDLE && ctl_ok && !launch_u && !launch_x) |=> (key_q == K_IDLE && !fl_start));
  p_busy_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fl_done) |=> (busy && $stable(fl_mask) && $stable(page_sel) && $stable(fl_page)));
  p_done_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fl_done) |=> (!busy && fl_mask == '0));

endmodule

// File: tb/tb_flash_page_seq.sv
module tb_flash_page_seq;
  logic clk = 0, rst_n = 0;
  logic cpu_we = 0, ctl_we = 0, fl_done = 0;
  logic [15:0] cpu_addr = 0;
  logic [7:0] cpu_wdata = 0, ctl_wdata = 0;
  logic [7:0] ctl_rdata;
  logic mem_we, fl_start, fl_space;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [8:0] fl_page;
  logic [1023:0] fl_data;
  logic [127:0] fl_mask;

  always #10 clk = ~clk;

  flash_page_seq dut (.clk, .rst_n, .cpu_we, .cpu_addr, .cpu_wdata, .ctl_we, .ctl_wdata,
    .ctl_rdata, .mem_we, .mem_addr, .mem_wdata, .fl_start, .fl_space, .fl_page,
    .fl_data, .fl_mask, .fl_done);

  int n_cmp = 0, n_bad = 0;
  bit m_sel, m_busy, m_start, m_space;
  int m_key, m_page;
  logic [7:0] m_buf [128];
  bit m_mask [128];

  task automatic chk(string tag, logic [1023:0] act, logic [1023:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [1023:0] ed;
    logic [127:0] em;
    for (int i = 0; i < 128; i++) begin
      ed[i*8 +: 8] = m_buf[i];
      em[i] = m_mask[i];
    end
    chk("R2 ctl_rdata", ctl_rdata, {4'b0, m_sel, 2'b0, m_busy});
    chk("R7/R10/R11 busy", ctl_rdata[0], m_busy);
    chk("R7/R8/R9 fl_start", fl_start, m_start);
    chk("R8 fl_space", fl_space, m_space);
    chk("R6 fl_page", fl_page, m_page);
    chk("R4/R5/R11 fl_mask", fl_mask, em);
    chk("R4 fl_data", fl_data, ed);
  endtask

  task automatic step(bit cwe, int addr, int wd, bit kwe, int kd, bit dn);
    bit ld, ob, ns;
    cpu_we = cwe; cpu_addr = addr[15:0]; cpu_wdata = wd[7:0];
    ctl_we = kwe; ctl_wdata = kd[7:0]; fl_done = dn;
    #1;
    chk("R3 mem_we", mem_we, cwe && !m_sel);
    if (cwe && !m_sel) begin
      chk("R3 mem_addr", mem_addr, addr[15:0]);
      chk("R3 mem_wdata", mem_wdata, wd[7:0]);
    end
    ob = m_busy; ns = 0;
    ld = cwe && m_sel && !ob && (addr <= 'h7FFF || addr >= 'hFF80);
    if (ld) begin
      m_buf[addr % 128] = wd[7:0];
      m_mask[addr % 128] = 1;
      m_page = addr / 128;
    end
    if (kwe && !ob) begin
      if (kd[7:4] == 0) m_sel = kd[3];
      if (m_key == 0) begin
        if (kd == 'h50) m_key = 1;
        else if (kd == 'h52) m_key = 2;
      end else begin
        if (m_key == 1 && kd == 'hA0) begin ns = 1; m_space = 0; end
        else if (m_key == 2 && kd == 'hA2) begin ns = 1; m_space = 1; end
        m_key = 0;
      end
    end
    if (ob && dn) begin
      m_busy = 0;
      for (int i = 0; i < 128; i++) m_mask[i] = 0;
    end
    if (ns) m_busy = 1;
    m_start = ns;
    @(posedge clk); @(negedge clk);
    compare_all();
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0); endtask
  task automatic cw(int d); step(0, 0, 0, 1, d, 0); endtask
  task automatic wr(int a, int d); step(1, a, d, 0, 0, 0); endtask
  task automatic done(); step(0, 0, 0, 0, 0, 1); endtask

  initial begin
    #5_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int seed = 7;
    m_sel = 0; m_busy = 0; m_start = 0; m_space = 0; m_key = 0; m_page = 0;
    for (int i = 0; i < 128; i++) begin m_buf[i] = 0; m_mask[i] = 0; end
    repeat (3) @(negedge clk);
    compare_all();                       // R1 reset state
    rst_n = 1;
    // R3 pass-through with page-select clear
    wr('h1234, 'h5A); wr('hFFFF, 'hC3); idle();
    // R2 set page-select; R3 writes now held back
    cw('h08);
    // R4 loads, R5 rejected addresses, R6 last page
    wr('h0000, 'h11); wr('h007F, 'h22); wr('h8000, 'h33); wr('hFF7F, 'h44);
    wr('h0105, 'h55); wr('h0106, 'h66);
    // R7 user launch, R10 busy with select still set
    cw('h50); cw('hA0);
    wr('h0107, 'h77); cw('h00); cw('h52); wr('hFFF0, 'h88); idle();
    // R11 done clears busy and mask, then idle done ignored
    done(); done(); idle();
    // R8 extra-row launch
    wr('hFF80, 'h99); wr('hFFFF, 'hAA); cw('h52); cw('hA2); idle(); done();
    // R9 broken sequences
    cw('h50); cw('hA2); cw('hA2);
    cw('h52); cw('h50); cw('hA0);
    cw('h50); cw('h08); cw('hA0);
    cw('hA0); cw('h52); cw('h52); cw('hA2);
    cw('h00); idle();
    // mixed stream
    for (int n = 0; n < 3000; n++) begin
      int r, a, kd;
      r = $urandom(seed) % 16; seed = seed + 1;
      case ($urandom % 3)
        0: a = $urandom % 'h8000;
        1: a = 'hFF80 + ($urandom % 128);
        default: a = $urandom % 'h10000;
      endcase
      case ($urandom % 8)
        0: kd = 'h00; 1: kd = 'h08; 2: kd = 'h50; 3: kd = 'h52;
        4: kd = 'hA0; 5: kd = 'hA2; default: kd = $urandom % 256;
      endcase
      step(r < 9, a, $urandom % 256, r >= 6 && r < 12, kd, ($urandom % 6) == 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule